// File: doc/BRIEF.md
# Host Byte-Port Mailbox with Input Buffers

This block gives an external host a single byte-wide register window, selected by a 2-bit address, onto an internal processor. Through it the host can do four things. It can exchange message bytes with the processor through a pair of one-way mailbox registers. It can read a status byte and write two buffer-hold bits. It can stream bytes into two small input FIFOs: one for linear PCM samples and one for compressed data.

Each mailbox direction has its own flag. The busy flag is set when the host leaves a byte and is cleared when the processor takes it. The ready flag is set when the processor leaves a byte and is cleared when the host takes it. Either side can poll its flag to pace the transfer.

Each FIFO has the following:
- a hold bit that empties the FIFO and keeps it empty;
- an almost-full indication, compared against a threshold input;
- a valid/ready drain port on the processor side.

The PCM FIFO also tags the first byte written after its hold is released. This tag marks the start of a left-channel sample.

Top module: `hpi_top`

## Requirements
- R1: The host read data is decoded from the address as follows. Address 0 returns the processor-to-host mailbox byte. Address 1 returns the status byte. Addresses 2 and 3 are write-only and read as 0x00.
- R2: A host write to address 0 loads the host-to-processor byte, which appears on `proc_msg_rdata`. A processor write loads the processor-to-host byte, which the host reads at address 0. The two registers are independent.
- R3: The busy flag (status bit 2, also on `proc_msg_busy`) works as follows:
  - it is set by a host write to address 0;
  - it is cleared by a processor read;
  - when both happen in the same cycle, it ends up set.
- R4: The ready flag (status bit 1, also on `proc_msg_ready`) works as follows:
  - it is set by a processor write;
  - it is cleared by a host read of address 0;
  - when both happen in the same cycle, it ends up set, and the host read returns the older byte.
- R5: The status byte carries these bits:
  - bit 4 is the PCM FIFO almost-full flag;
  - bit 3 is the compressed FIFO almost-full flag;
  - bit 2 is the busy flag;
  - bit 1 is the ready flag;
  - bits 7, 6, 5 and 0 always read 0.
- R6: A host write to address 1 sets the compressed hold from data bit 6 and the PCM hold from data bit 5. The other data bits have no effect: writing ones to the flag positions leaves the flags unchanged.
- R7: A host write to address 2 pushes one byte into the PCM FIFO. A write to address 3 pushes one byte into the compressed FIFO. Each FIFO delivers its bytes in write order through its valid/ready port, and one byte is removed per cycle in which valid and ready are both high.
- R8: A FIFO holds at most DEPTH bytes. A write to a full FIFO is dropped, and the stored bytes are kept unchanged.
- R9: A FIFO's almost-full flag is 1 exactly when its fill count is greater than or equal to its threshold input.
- R10: While a hold bit is 1, its FIFO is empty, its valid output is 0, and host writes to its address are ignored.
- R11: After the PCM hold changes from 1 to 0, the first byte accepted into the PCM FIFO comes out with `pcm_first` = 1. Every other byte comes out with `pcm_first` = 0.
- R12: After reset, the following hold:
  - both mailbox registers are 0x00;
  - both flags and both holds are 0;
  - both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of `host_rd` |
| proc_msg_wr | input | 1 | Processor writes the processor-to-host mailbox |
| proc_msg_rd | input | 1 | Processor takes the host-to-processor mailbox |
| proc_msg_wdata | input | 8 | Processor mailbox write data |
| proc_msg_rdata | output | 8 | Host-to-processor mailbox byte |
| proc_msg_busy | output | 1 | Busy flag, host byte not yet taken |
| proc_msg_ready | output | 1 | Ready flag, processor byte not yet taken |
| pcm_lvl | input | $clog2(DEPTH+1) | PCM almost-full threshold |
| cmp_lvl | input | $clog2(DEPTH+1) | Compressed almost-full threshold |
| pcm_valid | output | 1 | PCM FIFO has a byte |
| pcm_ready | input | 1 | Processor accepts a PCM byte |
| pcm_data | output | 8 | PCM FIFO head byte |
| pcm_first | output | 1 | Head byte is the first after a PCM hold release |
| cmp_valid | output | 1 | Compressed FIFO has a byte |
| cmp_ready | input | 1 | Processor accepts a compressed byte |
| cmp_data | output | 8 | Compressed FIFO head byte |

## Verification
The assertions check the following on every cycle:
- the set, clear and set-wins rules of both mailbox flags;
- that the reserved status bits are zero on every status read;
- that a held FIFO is flushed and shows no valid byte;
- that a full FIFO keeps its count when a write arrives.

Other behaviours can only be shown by the bench's scenarios:
- the byte ordering through each FIFO;
- the single first-sample tag after a PCM hold release;
- the independence of the two mailbox registers.

The bench also sweeps every threshold against every fill level. This shows that the almost-full flags track the count in both FIFOs.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_MSG  = 2'b00,
        SEL_CTRL = 2'b01,
        SEL_PCM  = 2'b10,
        SEL_CMP  = 2'b11
    } hpi_sel_e;

    // status / control bit positions
    localparam int CB_CMP_HOLD = 6;
    localparam int CB_PCM_HOLD = 5;
    localparam int CB_PCM_AF   = 4;
    localparam int CB_CMP_AF   = 3;
    localparam int CB_BUSY     = 2;
    localparam int CB_READY    = 1;

    typedef struct packed {
        logic               first;
        logic [BYTE_W-1:0]  data;
    } pcm_ent_t;

    localparam int PCM_ENT_W = $bits(pcm_ent_t);

    function automatic logic [BYTE_W-1:0] make_status(
        input logic pcm_af,
        input logic cmp_af,
        input logic busy,
        input logic ready
    );
        logic [BYTE_W-1:0] s;
        s              = '0;
        s[CB_PCM_AF]   = pcm_af;
        s[CB_CMP_AF]   = cmp_af;
        s[CB_BUSY]     = busy;
        s[CB_READY]    = ready;
        return s;
    endfunction

endpackage

// File: rtl/hpi_mailbox.sv
module hpi_mailbox
    import hpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              proc_wr,
    input  logic              proc_rd,
    input  logic [BYTE_W-1:0] proc_wdata,
    output logic [BYTE_W-1:0] to_proc_data,
    output logic [BYTE_W-1:0] to_host_data,
    output logic              to_proc_busy,
    output logic              to_host_ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            to_proc_data  <= '0;
            to_host_data  <= '0;
            to_proc_busy  <= 1'b0;
            to_host_ready <= 1'b0;
        end else begin
            if (host_wr) to_proc_data <= host_wdata;
            if (proc_wr) to_host_data <= proc_wdata;

            if (host_wr)      to_proc_busy <= 1'b1;
            else if (proc_rd) to_proc_busy <= 1'b0;

            if (proc_wr)      to_host_ready <= 1'b1;
            else if (host_rd) to_host_ready <= 1'b0;
        end
    end

    p_busy_set_r3: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> to_proc_busy);
    p_busy_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (proc_rd && !host_wr) |=> !to_proc_busy);
    p_busy_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (!proc_rd && !host_wr) |=> $stable(to_proc_busy));
    p_ready_set_r4: assert property (@(posedge clk) disable iff (rst)
        proc_wr |=> to_host_ready);
    p_ready_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !proc_wr) |=> !to_host_ready);
    p_msg_indep_r2: assert property (@(posedge clk) disable iff (rst)
        !proc_wr |=> $stable(to_host_data));

endmodule

// File: rtl/hpi_infifo.sv
module hpi_infifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             push,
    input  logic [W-1:0]     push_ent,
    input  logic [LVL_W-1:0] lvl,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [W-1:0]     pop_ent,
    output logic             afull,
    output logic             full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);
    localparam logic [PW-1:0]    LAST_IDX = PW'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full      = (cnt == FULL_CNT);
    assign pop_valid = (cnt != '0);
    assign pop_ent   = mem[rp];
    assign afull     = (cnt >= lvl);
    assign do_push   = push && !full && !hold;
    assign do_pop    = pop_valid && pop_ready && !hold;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);
    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop_ready && !hold) |=> (hold || full));
    p_hold_flush_r10: assert property (@(posedge clk) disable iff (rst)
        hold |=> !pop_valid);

endmodule

// File: rtl/hpi_top.sv
module hpi_top
    import hpi_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   host_addr,
    input  logic                         host_wr,
    input  logic                         host_rd,
    input  logic [7:0]                   host_wdata,
    output logic [7:0]                   host_rdata,
    input  logic                         proc_msg_wr,
    input  logic                         proc_msg_rd,
    input  logic [7:0]                   proc_msg_wdata,
    output logic [7:0]                   proc_msg_rdata,
    output logic                         proc_msg_busy,
    output logic                         proc_msg_ready,
    input  logic [$clog2(DEPTH+1)-1:0]   pcm_lvl,
    input  logic [$clog2(DEPTH+1)-1:0]   cmp_lvl,
    output logic                         pcm_valid,
    input  logic                         pcm_ready,
    output logic [7:0]                   pcm_data,
    output logic                         pcm_first,
    output logic                         cmp_valid,
    input  logic                         cmp_ready,
    output logic [7:0]                   cmp_data
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    hpi_sel_e sel;
    logic     msg_wr, msg_rd, ctrl_wr, pcm_wr, cmp_wr;
    logic     pcm_hold, cmp_hold, first_pend;
    logic     pcm_af, cmp_af, pcm_full, cmp_full;
    logic [BYTE_W-1:0] to_host_byte;
    pcm_ent_t pcm_in, pcm_out;

    assign sel     = hpi_sel_e'(host_addr);
    assign msg_wr  = host_wr && (sel == SEL_MSG);
    assign msg_rd  = host_rd && (sel == SEL_MSG);
    assign ctrl_wr = host_wr && (sel == SEL_CTRL);
    assign pcm_wr  = host_wr && (sel == SEL_PCM);
    assign cmp_wr  = host_wr && (sel == SEL_CMP);

    hpi_mailbox u_mbox (
        .clk           (clk),
        .rst           (rst),
        .host_wr       (msg_wr),
        .host_rd       (msg_rd),
        .host_wdata    (host_wdata),
        .proc_wr       (proc_msg_wr),
        .proc_rd       (proc_msg_rd),
        .proc_wdata    (proc_msg_wdata),
        .to_proc_data  (proc_msg_rdata),
        .to_host_data  (to_host_byte),
        .to_proc_busy  (proc_msg_busy),
        .to_host_ready (proc_msg_ready)
    );

    // hold bits and the first-sample marker armed by a PCM hold release
    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_hold   <= 1'b0;
            cmp_hold   <= 1'b0;
            first_pend <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                pcm_hold <= host_wdata[CB_PCM_HOLD];
                cmp_hold <= host_wdata[CB_CMP_HOLD];
            end
            if (ctrl_wr && pcm_hold && !host_wdata[CB_PCM_HOLD])
                first_pend <= 1'b1;
            else if (pcm_wr && !pcm_full && !pcm_hold)
                first_pend <= 1'b0;
        end
    end

    assign pcm_in.first = first_pend;
    assign pcm_in.data  = host_wdata;

    hpi_infifo #(.DEPTH(DEPTH), .W(PCM_ENT_W), .LVL_W(LVL_W)) u_pcm_fifo (
        .clk       (clk),
        .rst       (rst),
        .hold      (pcm_hold),
        .push      (pcm_wr),
        .push_ent  (pcm_in),
        .lvl       (pcm_lvl),
        .pop_ready (pcm_ready),
        .pop_valid (pcm_valid),
        .pop_ent   (pcm_out),
        .afull     (pcm_af),
        .full      (pcm_full)
    );

    assign pcm_data  = pcm_out.data;
    assign pcm_first = pcm_out.first;

    hpi_infifo #(.DEPTH(DEPTH), .W(BYTE_W), .LVL_W(LVL_W)) u_cmp_fifo (
        .clk       (clk),
        .rst       (rst),
        .hold      (cmp_hold),
        .push      (cmp_wr),
        .push_ent  (host_wdata),
        .lvl       (cmp_lvl),
        .pop_ready (cmp_ready),
        .pop_valid (cmp_valid),
        .pop_ent   (cmp_data),
        .afull     (cmp_af),
        .full      (cmp_full)
    );

    always_comb begin
        unique case (sel)
            SEL_MSG:  host_rdata = to_host_byte;
            SEL_CTRL: host_rdata = make_status(pcm_af, cmp_af, proc_msg_busy, proc_msg_ready);
            default:  host_rdata = '0;
        endcase
    end

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && sel == SEL_CTRL) |-> (host_rdata[7:5] == 3'b000 && !host_rdata[0]));
    p_pcm_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (pcm_hold && $past(pcm_hold)) |-> !pcm_valid);
    p_cmp_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_hold && $past(cmp_hold)) |-> !cmp_valid);
    p_wo_read_r1: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr[1]) |-> (host_rdata == 8'h00));

endmodule

// File: tb/tb_hpi_top.sv
`timescale 1ns/1ps
module tb_hpi_top;

    localparam int DEPTH = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       host_addr = '0;
    logic             host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]       host_wdata = '0, host_rdata;
    logic             proc_msg_wr = 1'b0, proc_msg_rd = 1'b0;
    logic [7:0]       proc_msg_wdata = '0, proc_msg_rdata;
    logic             proc_msg_busy, proc_msg_ready;
    logic [LVL_W-1:0] pcm_lvl = LVL_W'(DEPTH), cmp_lvl = LVL_W'(DEPTH);
    logic             pcm_valid, pcm_ready = 1'b0, pcm_first;
    logic [7:0]       pcm_data;
    logic             cmp_valid, cmp_ready = 1'b0;
    logic [7:0]       cmp_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hpi_top #(.DEPTH(DEPTH)) dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pwrite(input logic [7:0] d);
        @(negedge clk);
        proc_msg_wdata = d; proc_msg_wr = 1'b1;
        @(negedge clk);
        proc_msg_wr = 1'b0;
    endtask

    task automatic pread();
        @(negedge clk);
        proc_msg_rd = 1'b1;
        @(negedge clk);
        proc_msg_rd = 1'b0;
    endtask

    task automatic pop_pcm(input string req, input logic [7:0] ed, input logic ef);
        @(negedge clk);
        check(req, {15'd0, pcm_valid}, 16'd1);
        check(req, {7'd0, pcm_first, pcm_data}, {7'd0, ef, ed});
        pcm_ready = 1'b1;
        @(negedge clk);
        pcm_ready = 1'b0;
    endtask

    task automatic pop_cmp(input string req, input logic [7:0] ed);
        @(negedge clk);
        check(req, {15'd0, cmp_valid}, 16'd1);
        check(req, {8'd0, cmp_data}, {8'd0, ed});
        cmp_ready = 1'b1;
        @(negedge clk);
        cmp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        hread(2'b01, rd);  check("R12 status", {8'd0, rd}, 16'h0000);
        hread(2'b00, rd);  check("R12 to-host byte", {8'd0, rd}, 16'h0000);
        check("R12 to-proc byte", {8'd0, proc_msg_rdata}, 16'h0000);
        check("R12 fifos empty", {14'd0, pcm_valid, cmp_valid}, 16'h0000);

        // R2 / R3 host to processor
        hwrite(2'b00, 8'hA5);
        check("R2 to-proc byte", {8'd0, proc_msg_rdata}, 16'h00A5);
        hread(2'b01, rd);  check("R3 busy set", {15'd0, rd[2]}, 16'd1);
        check("R3 busy pin", {15'd0, proc_msg_busy}, 16'd1);
        pread();
        hread(2'b01, rd);  check("R3 busy cleared", {15'd0, rd[2]}, 16'd0);
        @(negedge clk);
        host_addr = 2'b00; host_wdata = 8'h5A; host_wr = 1'b1; proc_msg_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; proc_msg_rd = 1'b0;
        hread(2'b01, rd);  check("R3 same-cycle set wins", {15'd0, rd[2]}, 16'd1);
        pread();

        // R2 / R4 processor to host
        pwrite(8'h3C);
        hread(2'b01, rd);  check("R4 ready set", {15'd0, rd[1]}, 16'd1);
        check("R2 to-proc byte unchanged", {8'd0, proc_msg_rdata}, 16'h005A);
        hread(2'b00, rd);  check("R2 to-host byte", {8'd0, rd}, 16'h003C);
        hread(2'b01, rd);  check("R4 ready cleared", {15'd0, rd[1]}, 16'd0);
        @(negedge clk);
        host_addr = 2'b00; host_rd = 1'b1; proc_msg_wdata = 8'h77; proc_msg_wr = 1'b1;
        #1 rd = host_rdata;
        check("R4 same-cycle read old byte", {8'd0, rd}, 16'h003C);
        @(negedge clk);
        host_rd = 1'b0; proc_msg_wr = 1'b0;
        check("R4 same-cycle set wins", {15'd0, proc_msg_ready}, 16'd1);
        hread(2'b00, rd);  check("R4 new byte", {8'd0, rd}, 16'h0077);

        // R6 / R10 holds
        hwrite(2'b01, 8'hFF);
        hread(2'b01, rd);  check("R6 flag bits not writable", {8'd0, rd}, 16'h0000);
        hwrite(2'b10, 8'h11);
        hwrite(2'b11, 8'h22);
        check("R10 held fifos ignore writes", {14'd0, pcm_valid, cmp_valid}, 16'h0000);
        hwrite(2'b01, 8'h00);
        check("R10 nothing kept after release", {14'd0, pcm_valid, cmp_valid}, 16'h0000);

        // R7 / R11 ordering and first marker
        for (int i = 0; i < 3; i++) hwrite(2'b10, 8'h10 + 8'(i));
        for (int i = 0; i < 3; i++) hwrite(2'b11, 8'h80 + 8'(i));
        for (int i = 0; i < 3; i++) pop_pcm("R11 R7 pcm order/first", 8'h10 + 8'(i), (i == 0));
        for (int i = 0; i < 3; i++) pop_cmp("R7 cmp order", 8'h80 + 8'(i));
        @(negedge clk);
        check("R7 drained", {14'd0, pcm_valid, cmp_valid}, 16'h0000);

        // R8 overflow
        for (int i = 0; i < DEPTH + 2; i++) hwrite(2'b10, 8'h40 + 8'(i));
        for (int i = 0; i < DEPTH; i++) pop_pcm("R8 kept bytes", 8'h40 + 8'(i), 1'b0);
        @(negedge clk);
        check("R8 extra dropped", {15'd0, pcm_valid}, 16'd0);

        // R9 / R5 threshold sweep
        for (int lv = 0; lv <= DEPTH; lv++) begin
            for (int k = 0; k <= DEPTH; k++) begin
                @(negedge clk);
                pcm_lvl = LVL_W'(lv);
                cmp_lvl = LVL_W'(DEPTH - lv);
                hwrite(2'b01, 8'h60);
                hwrite(2'b01, 8'h00);
                for (int j = 0; j < k; j++) begin
                    hwrite(2'b10, 8'(j));
                    hwrite(2'b11, 8'(j));
                end
                hread(2'b01, rd);
                check("R9 pcm afull", {15'd0, rd[4]}, {15'd0, k >= lv});
                check("R9 cmp afull", {15'd0, rd[3]}, {15'd0, k >= (DEPTH - lv)});
                check("R5 reserved zero", {12'd0, rd[7:5], rd[0]}, 16'd0);
            end
        end

        // R1 write-only addresses
        hread(2'b10, rd);  check("R1 pcm port reads 0", {8'd0, rd}, 16'h0000);
        hread(2'b11, rd);  check("R1 cmp port reads 0", {8'd0, rd}, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule